// File: doc/BRIEF.md
# Half-bridge gate sequencer with dead-time interlock

This block turns two digital requests, one asking for the high-side switch of a half-bridge to conduct and one asking for the low-side switch, into two gate-enable outputs. Each request is brought into the clock domain through a two-flop synchroniser. It then passes a glitch filter that accepts a new level only after it has held for a set number of cycles. A sequencer then applies a turn-on delay that depends on the selected mode. It also applies a turn-off delay, a minimum conducting time, a minimum off interval for each gate and a dead time between the two sides. The two gates are never enabled together.

A shutdown input, driven synchronously by a separate protection block, forces both gates off at the next clock edge and overrides every timer while it is held. All delays are parameters counted in system clock cycles. The defaults assume a 10 MHz clock.

Top module: `hb_gate_ctrl`

## Requirements
- R1: `gate_hi` and `gate_lo` are never 1 in the same cycle. While both filtered requests are 1, neither gate may turn on, and a gate that is on turns off with the normal turn-off latency of R4.
- R2: Each request passes a two-flop synchroniser and then a filter that accepts a new level only after `FILT_CYC` consecutive sampling edges see it. A pulse seen on fewer edges has no effect on the gates.
- R3: Starting from both gates off with all guards satisfied, a gate rises `2+FILT_CYC+TON` cycles after the first clock edge that samples the new request level. `TON` is `TON_BI_CYC` when `mode_tri`=0 (bistate) and `TON_TRI_CYC` when `mode_tri`=1 (three-state).
- R4: Once the minimum on time has elapsed, a gate falls `1+FILT_CYC+TOFF_CYC` cycles after the first clock edge that samples the withdrawn request.
- R5: Unless shutdown is active, a gate that rises stays at 1 for at least `MIN_ON_CYC` cycles, even when its request has already been withdrawn.
- R6: After a gate falls, the same gate stays at 0 for at least `MIN_OFF_CYC` cycles. When this is the binding limit, the off interval is exactly `MIN_OFF_CYC` cycles.
- R7: Between one gate falling and the opposite gate rising, both gates are 0 for at least `DEAD_CYC` cycles. When this is the binding limit, the interval is exactly `DEAD_CYC` cycles.
- R8: A request that is withdrawn before its turn-on delay has elapsed never turns its gate on.
- R9: When `shutdown`=1 is sampled at a clock edge, both gates are 0 after that edge and stay 0 for as long as shutdown is held. When shutdown is released, a request that is still active turns its gate on again.
- R10: While `rst_n` is 0 at a clock edge, both gates are 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all timing counts its cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_hi_in | input | 1 | Asynchronous request for the high-side gate (1 = conduct) |
| cmd_lo_in | input | 1 | Asynchronous request for the low-side gate (1 = conduct) |
| mode_tri | input | 1 | Turn-on delay select: 0 = bistate (long), 1 = three-state (short) |
| shutdown | input | 1 | Synchronous forced-off from the protection block (1 = all off) |
| gate_hi | output | 1 | High-side gate enable |
| gate_lo | output | 1 | Low-side gate enable |

## Verification
The main function is driven with a table of clean request steps covering each side in each mode. This separates the two turn-on delays and shows that the turn-off path does not depend on the mode. Pulses of one cycle below, at and just above the filter length show where rejection ends. In bistate mode, the same pulse that passes the filter must still be dropped by the longer turn-on delay, and a pulse just past the filter length exposes the minimum on time. A short low gap in a held request checks the minimum off time. A hand-over between sides in each direction, both requests at once, and a shutdown during conduction check that the interlock and the dead time hold whichever timer is binding.

// File: rtl/hbg_pkg.sv
// Shared types and helpers for the half-bridge gate sequencer.
// Assumes: nothing beyond IEEE 1800-2017 constant functions.
package hbg_pkg;

    // Sequencer states: which side is waiting or conducting.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_HI_WAIT = 3'd1,
        ST_HI_ON   = 3'd2,
        ST_LO_WAIT = 3'd3,
        ST_LO_ON   = 3'd4
    } hbg_state_e;

    // Larger of two counts, used to size the shared timer width.
    function automatic int unsigned hbg_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/hbg_cmd_filter.sv
// Request conditioner for one side: two-flop synchroniser followed by a
// level filter that accepts a new level after FILT_CYC agreeing samples.
// Assumes: raw_in is asynchronous; FILT_CYC >= 1; CW holds FILT_CYC.
module hbg_cmd_filter #(
    parameter int FILT_CYC = 7,
    parameter int CW       = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic filt_out
);
    localparam logic [CW-1:0] FILT_LIM = CW'(FILT_CYC - 1);

    logic [1:0]    sync_q;
    logic          filt_q;
    logic [CW-1:0] agree_q;

    // Bring the raw request into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b00;
        else        sync_q <= {sync_q[0], raw_in};
    end

    // Count consecutive samples that differ from the accepted level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_q  <= 1'b0;
            agree_q <= '0;
        end else if (sync_q[1] != filt_q) begin
            if (agree_q >= FILT_LIM) begin
                filt_q  <= sync_q[1];
                agree_q <= '0;
            end else begin
                agree_q <= agree_q + 1'b1;
            end
        end else begin
            agree_q <= '0;
        end
    end

    assign filt_out = filt_q;

    AST_FILT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_q[1] == filt_q) |=> $stable(filt_q)); // R2

endmodule

// File: rtl/hbg_gap_timer.sv
// Saturating count of cycles since a gate was last on; used for the
// minimum off time of the same gate and the dead time of the opposite one.
// Assumes: reset starts saturated so the first turn-on is not held back.
module hbg_gap_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gate_in,
    output logic [CW-1:0] since_off
);
    logic [CW-1:0] cnt_q;

    // Clear while the gate conducts, count up (saturating) while it is off.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '1;
        else if (gate_in)       cnt_q <= '0;
        else if (cnt_q != '1)   cnt_q <= cnt_q + 1'b1;
    end

    assign since_off = cnt_q;

endmodule

// File: rtl/hbg_seq.sv
// Gate sequencer: chooses one side at a time, applies the mode-dependent
// turn-on delay, turn-off delay, minimum on time, minimum off time and
// dead time, and obeys a synchronous shutdown.
// Assumes: all *_CYC >= 1; CW is wide enough that all-ones exceeds every limit.
module hbg_seq
    import hbg_pkg::*;
#(
    parameter int TON_BI_CYC  = 32,
    parameter int TON_TRI_CYC = 10,
    parameter int TOFF_CYC    = 10,
    parameter int MIN_ON_CYC  = 4,
    parameter int MIN_OFF_CYC = 23,
    parameter int DEAD_CYC    = 45,
    parameter int CW          = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          f_hi,
    input  logic          f_lo,
    input  logic          mode_tri,
    input  logic          shutdown,
    input  logic [CW-1:0] hi_off_cnt,
    input  logic [CW-1:0] lo_off_cnt,
    output logic          gate_hi,
    output logic          gate_lo
);
    localparam logic [CW-1:0] TBI_LIM  = CW'(TON_BI_CYC - 1);
    localparam logic [CW-1:0] TTRI_LIM = CW'(TON_TRI_CYC - 1);
    localparam logic [CW-1:0] TOFF_LIM = CW'(TOFF_CYC - 1);
    localparam logic [CW-1:0] MON_LIM  = CW'(MIN_ON_CYC - 1);
    localparam logic [CW-1:0] MOFF_LIM = CW'(MIN_OFF_CYC - 1);
    localparam logic [CW-1:0] DEAD_LIM = CW'(DEAD_CYC - 1);

    hbg_state_e    state_q, state_d;
    logic [CW-1:0] tmr_q, tmr_d;
    logic [CW-1:0] offd_q, offd_d;
    logic          gate_hi_q, gate_lo_q;
    logic          req_hi, req_lo;
    logic [CW-1:0] ton_lim;
    logic          hi_may_on, lo_may_on;
    logic          hi_release, lo_release;

    // Saturating increment shared by the state timers.
    function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
        return (v == '1) ? v : v + 1'b1;
    endfunction

    // Conflicting requests cancel each other.
    assign req_hi = f_hi & ~f_lo;
    assign req_lo = f_lo & ~f_hi;

    // Turn-on delay chosen by the mode input.
    assign ton_lim = mode_tri ? TTRI_LIM : TBI_LIM;

    // Turn-on guards: delay done, own off time done, opposite dead time done.
    assign hi_may_on = (tmr_q >= ton_lim) && (hi_off_cnt >= MOFF_LIM) && (lo_off_cnt >= DEAD_LIM);
    assign lo_may_on = (tmr_q >= ton_lim) && (lo_off_cnt >= MOFF_LIM) && (hi_off_cnt >= DEAD_LIM);

    // Turn-off guards: request gone long enough and minimum on time done.
    assign hi_release = !req_hi && (offd_q >= TOFF_LIM) && (tmr_q >= MON_LIM);
    assign lo_release = !req_lo && (offd_q >= TOFF_LIM) && (tmr_q >= MON_LIM);

    // Next state and timer values.
    always_comb begin
        state_d = state_q;
        tmr_d   = sat_inc(tmr_q);
        offd_d  = offd_q;
        if (shutdown) begin
            state_d = ST_IDLE;
            tmr_d   = '0;
            offd_d  = '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    tmr_d  = '0;
                    offd_d = '0;
                    if (req_hi)      state_d = ST_HI_WAIT;
                    else if (req_lo) state_d = ST_LO_WAIT;
                end
                ST_HI_WAIT: begin
                    if (!req_hi) begin
                        state_d = ST_IDLE;
                        tmr_d   = '0;
                    end else if (hi_may_on) begin
                        state_d = ST_HI_ON;
                        tmr_d   = '0;
                        offd_d  = '0;
                    end
                end
                ST_HI_ON: begin
                    if (hi_release) begin
                        state_d = ST_IDLE;
                        tmr_d   = '0;
                        offd_d  = '0;
                    end else if (!req_hi) begin
                        offd_d = sat_inc(offd_q);
                    end else begin
                        offd_d = '0;
                    end
                end
                ST_LO_WAIT: begin
                    if (!req_lo) begin
                        state_d = ST_IDLE;
                        tmr_d   = '0;
                    end else if (lo_may_on) begin
                        state_d = ST_LO_ON;
                        tmr_d   = '0;
                        offd_d  = '0;
                    end
                end
                ST_LO_ON: begin
                    if (lo_release) begin
                        state_d = ST_IDLE;
                        tmr_d   = '0;
                        offd_d  = '0;
                    end else if (!req_lo) begin
                        offd_d = sat_inc(offd_q);
                    end else begin
                        offd_d = '0;
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    tmr_d   = '0;
                    offd_d  = '0;
                end
            endcase
        end
    end

    // State, timers and glitch-free registered gate enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            tmr_q     <= '0;
            offd_q    <= '0;
            gate_hi_q <= 1'b0;
            gate_lo_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            tmr_q     <= tmr_d;
            offd_q    <= offd_d;
            gate_hi_q <= (state_d == ST_HI_ON);
            gate_lo_q <= (state_d == ST_LO_ON);
        end
    end

    assign gate_hi = gate_hi_q;
    assign gate_lo = gate_lo_q;

    AST_SHDN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |=> (!gate_hi_q && !gate_lo_q)); // R9

    generate
        if (MIN_ON_CYC >= 2) begin : g_min_on_chk
            AST_MIN_ON_HI: assert property (@(posedge clk) disable iff (!rst_n)
                ($rose(gate_hi_q) && !shutdown) |=> gate_hi_q); // R5
            AST_MIN_ON_LO: assert property (@(posedge clk) disable iff (!rst_n)
                ($rose(gate_lo_q) && !shutdown) |=> gate_lo_q); // R5
        end
    endgenerate

endmodule

// File: rtl/hb_gate_ctrl.sv
// Half-bridge gate sequencer top: conditions both requests, tracks the
// off time of each gate and sequences the two gate enables.
// Assumes: shutdown is synchronous to clk; requests may be asynchronous.
module hb_gate_ctrl
    import hbg_pkg::*;
#(
    parameter int FILT_CYC    = 7,
    parameter int TON_BI_CYC  = 32,
    parameter int TON_TRI_CYC = 10,
    parameter int TOFF_CYC    = 10,
    parameter int MIN_ON_CYC  = 4,
    parameter int MIN_OFF_CYC = 23,
    parameter int DEAD_CYC    = 45
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_hi_in,
    input  logic cmd_lo_in,
    input  logic mode_tri,
    input  logic shutdown,
    output logic gate_hi,
    output logic gate_lo
);
    localparam int unsigned MAX_CYC = hbg_max(hbg_max(hbg_max(FILT_CYC, TON_BI_CYC),
                                                      hbg_max(TON_TRI_CYC, TOFF_CYC)),
                                              hbg_max(hbg_max(MIN_ON_CYC, MIN_OFF_CYC),
                                                      DEAD_CYC));
    localparam int CW    = $clog2(MAX_CYC + 1) + 1;
    localparam int SIDES = 2;

    logic [SIDES-1:0] raw_vec;
    logic [SIDES-1:0] filt_vec;
    logic [SIDES-1:0] gate_vec;
    logic [CW-1:0]    since_off [SIDES];

    assign raw_vec  = {cmd_lo_in, cmd_hi_in};
    assign gate_vec = {gate_lo, gate_hi};

    // One conditioner and one off-time tracker per side (0 = high, 1 = low).
    generate
        for (genvar s = 0; s < SIDES; s++) begin : g_side
            hbg_cmd_filter #(.FILT_CYC(FILT_CYC), .CW(CW)) u_filt (
                .clk      (clk),
                .rst_n    (rst_n),
                .raw_in   (raw_vec[s]),
                .filt_out (filt_vec[s])
            );
            hbg_gap_timer #(.CW(CW)) u_gap (
                .clk       (clk),
                .rst_n     (rst_n),
                .gate_in   (gate_vec[s]),
                .since_off (since_off[s])
            );
        end
    endgenerate

    hbg_seq #(
        .TON_BI_CYC  (TON_BI_CYC),
        .TON_TRI_CYC (TON_TRI_CYC),
        .TOFF_CYC    (TOFF_CYC),
        .MIN_ON_CYC  (MIN_ON_CYC),
        .MIN_OFF_CYC (MIN_OFF_CYC),
        .DEAD_CYC    (DEAD_CYC),
        .CW          (CW)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .f_hi       (filt_vec[0]),
        .f_lo       (filt_vec[1]),
        .mode_tri   (mode_tri),
        .shutdown   (shutdown),
        .hi_off_cnt (since_off[0]),
        .lo_off_cnt (since_off[1]),
        .gate_hi    (gate_hi),
        .gate_lo    (gate_lo)
    );

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi && gate_lo)); // R1
    AST_DEAD_GAP_LO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_lo) |-> !$past(gate_hi)); // R7
    AST_DEAD_GAP_HI: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_hi) |-> !$past(gate_lo)); // R7

endmodule

// File: tb/hb_gate_ctrl_test.sv
// Self-checking bench for hb_gate_ctrl with shortened timing parameters.
module hb_gate_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int B_FILT    = 3;
    localparam int B_TON_BI  = 5;
    localparam int B_TON_TRI = 2;
    localparam int B_TOFF    = 2;
    localparam int B_MIN_ON  = 4;
    localparam int B_MIN_OFF = 6;
    localparam int B_DEAD    = 8;
    localparam int LIMIT     = 200;

    typedef struct packed {
        logic       side;
        logic       mode;
        logic [7:0] exp_rise;
        logic [7:0] exp_fall;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{1'b0, 1'b0, 8'(3 + B_FILT + B_TON_BI),  8'(2 + B_FILT + B_TOFF)},
        '{1'b1, 1'b0, 8'(3 + B_FILT + B_TON_BI),  8'(2 + B_FILT + B_TOFF)},
        '{1'b0, 1'b1, 8'(3 + B_FILT + B_TON_TRI), 8'(2 + B_FILT + B_TOFF)},
        '{1'b1, 1'b1, 8'(3 + B_FILT + B_TON_TRI), 8'(2 + B_FILT + B_TOFF)}
    };

    logic clk = 1'b0;
    logic rst_n, cmd_hi_in, cmd_lo_in, mode_tri, shutdown;
    logic gate_hi, gate_lo;
    int   checks = 0;
    int   errors = 0;
    int   overlaps = 0;
    bit   done = 1'b0;

    hb_gate_ctrl #(
        .FILT_CYC(B_FILT), .TON_BI_CYC(B_TON_BI), .TON_TRI_CYC(B_TON_TRI),
        .TOFF_CYC(B_TOFF), .MIN_ON_CYC(B_MIN_ON), .MIN_OFF_CYC(B_MIN_OFF),
        .DEAD_CYC(B_DEAD)
    ) uut (
        .clk(clk), .rst_n(rst_n), .cmd_hi_in(cmd_hi_in), .cmd_lo_in(cmd_lo_in),
        .mode_tri(mode_tri), .shutdown(shutdown), .gate_hi(gate_hi), .gate_lo(gate_lo)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) if (rst_n && gate_hi && gate_lo) overlaps++;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_cmd(input logic side, input logic val);
        if (side) cmd_lo_in = val;
        else      cmd_hi_in = val;
    endtask

    function automatic logic gate_of(input logic side);
        return side ? gate_lo : gate_hi;
    endfunction

    // Count posedges until the chosen gate reaches lvl (sampled at negedge).
    task automatic wait_gate(input logic side, input logic lvl, output int n);
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end while (gate_of(side) !== lvl && n < LIMIT);
    endtask

    // Count cycles over a window in which the chosen gate is 1.
    task automatic count_high(input logic side, input int cyc, output int hits);
        hits = 0;
        for (int k = 0; k < cyc; k++) begin
            @(negedge clk);
            if (gate_of(side)) hits++;
        end
    endtask

    task automatic idle(input int cyc);
        repeat (cyc) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n, h;
        rst_n = 1'b0; cmd_hi_in = 1'b0; cmd_lo_in = 1'b0;
        mode_tri = 1'b0; shutdown = 1'b0;
        cmd_hi_in = 1'b1;
        idle(3);
        check("R10 gate_hi in reset", int'(gate_hi), 0);
        check("R10 gate_lo in reset", int'(gate_lo), 0);
        cmd_hi_in = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(5);

        // Table of clean request steps: each side in each mode.
        for (int i = 0; i < 4; i++) begin
            mode_tri = VECS[i].mode;
            set_cmd(VECS[i].side, 1'b1);
            wait_gate(VECS[i].side, 1'b1, n);
            check("R3 turn-on latency", n, int'(VECS[i].exp_rise));
            check("R1 other gate idle", int'(gate_of(!VECS[i].side)), 0);
            idle(10);
            set_cmd(VECS[i].side, 1'b0);
            wait_gate(VECS[i].side, 1'b0, n);
            check("R4 turn-off latency", n, int'(VECS[i].exp_fall));
            idle(30);
        end

        // R2: pulse one sample short of the filter is ignored.
        mode_tri = 1'b1;
        cmd_hi_in = 1'b1; idle(B_FILT - 1); cmd_hi_in = 1'b0;
        count_high(1'b0, 30, h);
        check("R2 short pulse rejected", h, 0);

        // R2: pulse of exactly the filter length passes in three-state mode.
        cmd_hi_in = 1'b1; idle(B_FILT); cmd_hi_in = 1'b0;
        wait_gate(1'b0, 1'b1, n);
        check("R2 filter-length pulse passes", int'(n < LIMIT), 1);
        wait_gate(1'b0, 1'b0, n);
        idle(30);

        // R8: same pulse in bistate mode is withdrawn before the turn-on delay.
        mode_tri = 1'b0;
        cmd_hi_in = 1'b1; idle(B_FILT); cmd_hi_in = 1'b0;
        count_high(1'b0, 30, h);
        check("R8 withdrawn request stays off", h, 0);

        // R5: request released right after turn-on still gives MIN_ON cycles.
        mode_tri = 1'b1;
        cmd_hi_in = 1'b1; idle(B_FILT + 1); cmd_hi_in = 1'b0;
        wait_gate(1'b0, 1'b1, n);
        wait_gate(1'b0, 1'b0, n);
        check("R5 minimum on width", n, B_MIN_ON);
        idle(30);

        // R6: brief low gap in a held request gives MIN_OFF off cycles.
        cmd_hi_in = 1'b1;
        wait_gate(1'b0, 1'b1, n);
        idle(10);
        cmd_hi_in = 1'b0; idle(B_FILT + 1); cmd_hi_in = 1'b1;
        wait_gate(1'b0, 1'b0, n);
        wait_gate(1'b0, 1'b1, n);
        check("R6 minimum off width", n, B_MIN_OFF);
        cmd_hi_in = 1'b0;
        wait_gate(1'b0, 1'b0, n);
        idle(30);

        // R7: hand-over high to low in bistate, then low to high in three-state.
        mode_tri = 1'b0;
        cmd_hi_in = 1'b1;
        wait_gate(1'b0, 1'b1, n);
        idle(10);
        cmd_hi_in = 1'b0; cmd_lo_in = 1'b1;
        wait_gate(1'b0, 1'b0, n);
        wait_gate(1'b1, 1'b1, n);
        check("R7 dead time high to low", n, B_DEAD);
        idle(20);
        mode_tri = 1'b1;
        cmd_lo_in = 1'b0; cmd_hi_in = 1'b1;
        wait_gate(1'b1, 1'b0, n);
        wait_gate(1'b0, 1'b1, n);
        check("R7 dead time low to high", n, B_DEAD);
        idle(10);

        // R1: both requests at once turn the active gate off, other stays off.
        cmd_lo_in = 1'b1;
        wait_gate(1'b0, 1'b0, n);
        check("R1 conflict turns gate off", n, 2 + B_FILT + B_TOFF);
        count_high(1'b1, 30, h);
        check("R1 conflict keeps low gate off", h, 0);
        cmd_hi_in = 1'b0; cmd_lo_in = 1'b0;
        idle(30);

        // R9: shutdown during conduction.
        cmd_hi_in = 1'b1;
        wait_gate(1'b0, 1'b1, n);
        idle(5);
        shutdown = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R9 gate off one edge after shutdown", int'(gate_hi), 0);
        count_high(1'b0, 20, h);
        check("R9 gate held off during shutdown", h, 0);
        shutdown = 1'b0;
        wait_gate(1'b0, 1'b1, n);
        check("R9 gate returns after release", int'(n < LIMIT), 1);
        cmd_hi_in = 1'b0;
        wait_gate(1'b0, 1'b0, n);
        idle(10);

        check("R1 overlap cycles", overlaps, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule